// File: doc/BRIEF.md
# Buffered Serial Port Host Register Block

This block is the processor-facing side of a buffered serial port. A 32-bit memory-mapped slave exposes a data word, a control word, a baud word, a write-only action word and a read-only status word. Two 16-entry character queues sit behind the data word, one per direction. A separate line engine does the serial framing and the bit clock. It delivers received bytes and error strobes to this block, drains transmit bytes through a valid/ready pair, and supplies a one-cycle pulse per bit time.

Every sticky flag changes only through hardware events or through one-hot bits written to the action word. A received byte must first be moved from the queue into a holding register by a pop action; only then can it be read from the data word. Transmit-ready follows a programmable queue-fill threshold. Receive-ready comes up only after a programmable number of bit times has passed since a byte landed in an empty receive queue. One interrupt line ORs each flag with its enable bit.

Top module: `serial_host_regs`

## Requirements
- R1: After reset, control and baud read 0, status reads 0x00000002 (only transmit-ready, because the empty transmit queue does not exceed the reset threshold of 0), and irq is low.
- R2: Control bits 25:0 and baud bits 15:0 read back as written, and the higher bits read 0. line_cfg mirrors control bits 13:6 and baud_cfg mirrors baud bits 15:0.
- R3: A write to word 0 queues wdata[7:0] for transmit. The queue holds 16 bytes and drops a write made while it is full. Bytes appear on tx_data in order while tx_valid is high, and one leaves per cycle with tx_ready high. Status bits 15:11 give the transmit count.
- R4: Received bytes enter a 16-entry queue, and status bits 10:6 give its count. Action bit 10 moves the oldest byte into the holding register, which reads on data bits 7:0. A pop on an empty queue leaves both the holding register and the count unchanged.
- R5: A byte delivered while the receive queue is full is discarded and sets overrun (status bit 2). Sixteen bytes alone do not set it.
- R6: The break, framing-error and parity-error strobes set status bits 3, 4 and 5 respectively. The flags stay set until cleared.
- R7: Action bits 0..4 clear, and bits 5..9 set, receive-ready, overrun, break, framing error and parity error (in that order). If one write both sets and clears the same flag, the flag ends up set.
- R8: Action bit 11 empties the receive queue and action bit 12 empties the transmit queue.
- R9: Transmit-ready (status bit 1) is set in every cycle in which the transmit count is at most control bits 25:22. Action bit 13 clears it, but the clear holds only while the count is above that threshold. Action bit 14 sets it.
- R10: When a byte enters an empty receive queue, receive-ready (status bit 0) is raised once control bits 21:14 bit_tick pulses have followed. With a delay of 0 it is raised on the next cycle.
- R11: irq is high when any control enable bit 0..5 is set together with its flag: receive-ready, overrun, break, framing error, parity error and transmit-ready, in that order.
- R12: Writes to the status word change nothing, and the action word reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Byte address; bits 4:2 select the word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the addressed word |
| rx_valid | input | 1 | Line engine delivers a received byte |
| rx_data | input | 8 | Received byte |
| rx_brk | input | 1 | Break detected strobe |
| rx_fe | input | 1 | Framing error strobe |
| rx_pe | input | 1 | Parity error strobe |
| bit_tick | input | 1 | One pulse per serial bit time |
| tx_valid | output | 1 | Transmit queue not empty |
| tx_data | output | 8 | Oldest queued transmit byte |
| tx_ready | input | 1 | Line engine takes the offered byte |
| line_cfg | output | 8 | Framing settings: control bits 13:6 |
| baud_cfg | output | 16 | Baud divider word |
| irq | output | 1 | Combined interrupt |

## Verification
The bench sweeps every transmit threshold against every transmit fill level from 0 to 16. A design with an off-by-one or strict comparison would report transmit-ready one byte early or late. Both queues are filled one byte past capacity. A design that wraps its pointer would corrupt the first byte or count 0, and a design that flags overrun at 16 would raise it too early. The receive-ready delay is stepped tick by tick for several delay values, which exposes a counter that fires one tick early or that counts from the wrong event. The bench also writes a set and a clear of the same flag together, pops an empty queue, and maps each interrupt enable separately, because the enable order differs from the status order.

// File: rtl/shr_pkg.sv
package shr_pkg;
  // Word index taken from addr[4:2]
  localparam logic [2:0] W_DATA = 3'd0;
  localparam logic [2:0] W_CTRL = 3'd1;
  localparam logic [2:0] W_BAUD = 3'd2;
  localparam logic [2:0] W_ACT  = 3'd3;
  localparam logic [2:0] W_STAT = 3'd4;

  // Sticky receive flags, in enable / action order
  localparam int F_RRDY = 0;
  localparam int F_OE   = 1;
  localparam int F_BRK  = 2;
  localparam int F_FE   = 3;
  localparam int F_PE   = 4;
  localparam int NFLAG  = 5;

  // Action word bits
  localparam int A_SET_BASE = 5;
  localparam int A_POP      = 10;
  localparam int A_RXCLR    = 11;
  localparam int A_TXCLR    = 12;
  localparam int A_TCLR     = 13;
  localparam int A_TSET     = 14;

  // Control word fields
  localparam int C_EN_TRDY = 5;
  localparam int C_LINE_LO = 6;
  localparam int C_DLY_LO  = 14;
  localparam int C_THR_LO  = 22;
  localparam int C_W       = 26;
endpackage

// File: rtl/shr_fifo.sv
// Circular queue; DEPTH must be a power of two.
module shr_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  input  logic          clear,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full && !clear;
  assign do_pop  = pop && !empty && !clear;
  assign head    = mem[rp_q];
  assign count   = cnt_q;

  always_comb begin
    wp_n  = wp_q;
    rp_n  = rp_q;
    cnt_n = cnt_q;
    if (clear) begin
      wp_n  = '0;
      rp_n  = '0;
      cnt_n = '0;
    end else begin
      if (do_push) wp_n = wp_q + 1'b1;
      if (do_pop)  rp_n = rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_n = cnt_q + 1'b1;
        2'b01:   cnt_n = cnt_q - 1'b1;
        default: cnt_n = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end

  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  p_push_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !clear && !full) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/shr_rdy_timer.sv
// Counts bit ticks after the first byte reaches an empty receive queue.
module shr_rdy_timer #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             tick,
  input  logic [DLY_W-1:0] dly,
  output logic             fire
);
  logic             armed_q, armed_n;
  logic [DLY_W-1:0] cnt_q, cnt_n;

  assign fire = armed_q && (cnt_q >= dly);

  always_comb begin
    armed_n = armed_q;
    cnt_n   = cnt_q;
    if (start) begin
      armed_n = 1'b1;
      cnt_n   = '0;
    end else if (stop || fire) begin
      armed_n = 1'b0;
    end else if (armed_q && tick) begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      armed_q <= armed_n;
      cnt_q   <= cnt_n;
    end
  end

  p_single_fire_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !start) |=> !fire);
endmodule

// File: rtl/serial_host_regs.sv
module serial_host_regs
  import shr_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DLY_W  = 8,
  parameter int THR_W  = 4,
  parameter int BAUD_W = 16,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [4:0]        addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_brk,
  input  logic              rx_fe,
  input  logic              rx_pe,
  input  logic              bit_tick,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_ready,
  output logic [7:0]        line_cfg,
  output logic [BAUD_W-1:0] baud_cfg,
  output logic              irq
);
  logic [C_W-1:0]    ctrl_q, ctrl_n;
  logic [BAUD_W-1:0] baud_q, baud_n;
  logic [7:0]        hold_q, hold_n;
  logic [NFLAG-1:0]  flags_q, flags_n, hw_set;
  logic              trdy_q, trdy_n;

  logic [2:0]  word;
  logic        wr_act, wr_data;
  logic [14:0] act;
  logic        rx_pop, rx_clr, tx_clr, rx_push_ok;
  logic [7:0]  rx_head;
  logic [CW-1:0] rx_cnt, tx_cnt;
  logic        rx_full, rx_empty, tx_full, tx_empty;
  logic        rdy_fire;
  logic [THR_W-1:0] thr;
  logic [DLY_W-1:0] dly;
  logic [31:0] stat;
  logic        unused_bits;

  assign word    = addr[4:2];
  assign wr_act  = wr_en && (word == W_ACT);
  assign wr_data = wr_en && (word == W_DATA);
  assign act     = wr_act ? wdata[14:0] : '0;
  assign rx_pop  = act[A_POP];
  assign rx_clr  = act[A_RXCLR];
  assign tx_clr  = act[A_TXCLR];
  assign thr     = ctrl_q[C_THR_LO +: THR_W];
  assign dly     = ctrl_q[C_DLY_LO +: DLY_W];
  assign unused_bits = ^{wdata[31:C_W], addr[1:0], tx_full};

  // Receive side
  shr_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_valid), .din(rx_data),
    .pop(rx_pop), .clear(rx_clr), .head(rx_head), .count(rx_cnt),
    .full(rx_full), .empty(rx_empty)
  );

  assign rx_push_ok = rx_valid && !rx_full && !rx_clr;

  shr_rdy_timer #(.DLY_W(DLY_W)) u_rdy (
    .clk(clk), .rst_n(rst_n),
    .start(rx_push_ok && rx_empty),
    .stop(rx_clr || rx_empty),
    .tick(bit_tick), .dly(dly), .fire(rdy_fire)
  );

  // Transmit side
  shr_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(wr_data), .din(wdata[7:0]),
    .pop(tx_ready), .clear(tx_clr), .head(tx_data), .count(tx_cnt),
    .full(tx_full), .empty(tx_empty)
  );
  assign tx_valid = !tx_empty;

  // Sticky flags: hardware or action set beats action clear
  assign hw_set[F_RRDY] = rdy_fire;
  assign hw_set[F_OE]   = rx_valid && rx_full && !rx_clr;
  assign hw_set[F_BRK]  = rx_brk;
  assign hw_set[F_FE]   = rx_fe;
  assign hw_set[F_PE]   = rx_pe;

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    assign flags_n[i] = hw_set[i] || act[A_SET_BASE + i] ||
                        (flags_q[i] && !act[i]);

    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_act && wdata[i] && wdata[A_SET_BASE + i]) |=> flags_q[i]);
  end

  // Next state for configuration, hold register and transmit-ready
  always_comb begin
    ctrl_n = ctrl_q;
    baud_n = baud_q;
    hold_n = hold_q;
    if (wr_en && (word == W_CTRL)) ctrl_n = wdata[C_W-1:0];
    if (wr_en && (word == W_BAUD)) baud_n = wdata[BAUD_W-1:0];
    if (rx_pop && !rx_empty && !rx_clr) hold_n = rx_head;
    trdy_n = (tx_cnt <= CW'(thr)) || act[A_TSET] ||
             (trdy_q && !act[A_TCLR]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      baud_q  <= '0;
      hold_q  <= '0;
      flags_q <= '0;
      trdy_q  <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_n;
      baud_q  <= baud_n;
      hold_q  <= hold_n;
      flags_q <= flags_n;
      trdy_q  <= trdy_n;
    end
  end

  // Read path
  always_comb begin
    stat = '0;
    stat[0] = flags_q[F_RRDY];
    stat[1] = trdy_q;
    stat[2] = flags_q[F_OE];
    stat[3] = flags_q[F_BRK];
    stat[4] = flags_q[F_FE];
    stat[5] = flags_q[F_PE];
    stat[6 +: CW]      = rx_cnt;
    stat[6 + CW +: CW] = tx_cnt;
  end

  always_comb begin
    rdata = '0;
    case (word)
      W_DATA:  rdata[7:0]        = hold_q;
      W_CTRL:  rdata[C_W-1:0]    = ctrl_q;
      W_BAUD:  rdata[BAUD_W-1:0] = baud_q;
      W_STAT:  rdata             = stat;
      default: rdata             = '0;
    endcase
  end

  assign line_cfg = ctrl_q[C_LINE_LO +: 8];
  assign baud_cfg = baud_q;
  assign irq = |(ctrl_q[C_EN_TRDY:0] & {trdy_q, flags_q});

  p_overrun_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_full && !rx_clr) |=> flags_q[F_OE]);

  p_trdy_thr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= CW'(thr)) |=> trdy_q);

  p_pop_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && rx_empty) |=> $stable(hold_q));
endmodule

// File: tb/serial_host_regs_test.sv
module serial_host_regs_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, wr_en, rx_valid, rx_brk, rx_fe, rx_pe, bit_tick, tx_ready;
  logic [4:0]  addr;
  logic [31:0] wdata, rdata;
  logic [7:0]  rx_data, tx_data, line_cfg;
  logic [15:0] baud_cfg;
  logic        tx_valid, irq;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  serial_host_regs uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rx_valid(rx_valid), .rx_data(rx_data), .rx_brk(rx_brk),
    .rx_fe(rx_fe), .rx_pe(rx_pe), .bit_tick(bit_tick), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .line_cfg(line_cfg),
    .baud_cfg(baud_cfg), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] a, input logic [31:0] e);
    checks++;
    if (a !== e) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic action(input logic [31:0] bits);
    wr(5'd12, bits);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rx_byte(input logic [7:0] d);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic tick_once();
    @(negedge clk);
    bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0;
  endtask

  function automatic logic [31:0] rxc(input logic [31:0] s);
    return (s >> 6) & 32'h1f;
  endfunction

  function automatic logic [31:0] txc(input logic [31:0] s);
    return (s >> 11) & 32'h1f;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] s;
    rst_n = 0; wr_en = 0; addr = 0; wdata = 0; rx_valid = 0; rx_data = 0;
    rx_brk = 0; rx_fe = 0; rx_pe = 0; bit_tick = 0; tx_ready = 0;
    idle(3);
    rst_n = 1;
    idle(2);

    // R1 reset state
    rd(5'd4, v);  check("R1 ctrl", v, 32'h0);
    rd(5'd8, v);  check("R1 baud", v, 32'h0);
    rd(5'd16, v); check("R1 status", v, 32'h2);
    check("R1 irq", {31'b0, irq}, 32'h0);

    // R2 readback and config outputs
    wr(5'd4, 32'hFFFF_FFC0);
    rd(5'd4, v); check("R2 ctrl all", v, 32'h03FF_FFC0);
    check("R2 line_cfg all", {24'b0, line_cfg}, 32'hFF);
    wr(5'd4, 32'h0000_2A40);
    rd(5'd4, v); check("R2 ctrl pat", v, 32'h0000_2A40);
    check("R2 line_cfg pat", {24'b0, line_cfg}, 32'hA9);
    wr(5'd8, 32'hFFFF_1234);
    rd(5'd8, v); check("R2 baud", v, 32'h0000_1234);
    check("R2 baud_cfg", {16'b0, baud_cfg}, 32'h1234);
    wr(5'd4, 32'h0);

    // R12 status write ignored, action reads 0
    wr(5'd16, 32'hFFFF_FFFF);
    rd(5'd16, v); check("R12 status write ignored", v, 32'h2);
    rd(5'd12, v); check("R12 action reads 0", v, 32'h0);

    // R3 transmit queue fill, overflow drop, ordered drain
    for (int i = 1; i <= 17; i++) begin
      wr(5'd0, 32'h30 + i - 1);
      rd(5'd16, s);
      check("R3 tx count", txc(s), (i > 16) ? 32'd16 : i);
    end
    check("R3 tx_valid full", {31'b0, tx_valid}, 32'h1);
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      check("R3 tx order", {24'b0, tx_data}, 32'h30 + k);
      tx_ready = 1'b1;
      @(negedge clk);
      tx_ready = 1'b0;
    end
    rd(5'd16, s);
    check("R3 tx drained", txc(s), 32'd0);
    check("R3 tx_valid empty", {31'b0, tx_valid}, 32'h0);

    // R9 threshold sweep
    for (int t = 0; t < 16; t++) begin
      wr(5'd4, t << 22);
      action(32'h1 << 12);
      for (int n = 0; n <= 16; n++) begin
        if (n > 0) wr(5'd0, n);
        action(32'h1 << 13);
        rd(5'd16, s);
        check("R9 trdy vs threshold", (s >> 1) & 32'h1, (n <= t) ? 32'd1 : 32'd0);
      end
    end
    wr(5'd4, 32'h0);
    action(32'h1 << 13);
    rd(5'd16, s); check("R9 trdy cleared above thr", (s >> 1) & 32'h1, 32'd0);
    action(32'h1 << 14);
    rd(5'd16, s); check("R9 trdy set action", (s >> 1) & 32'h1, 32'd1);

    // R8 transmit clear
    action(32'h1 << 12);
    rd(5'd16, s); check("R8 tx clear count", txc(s), 32'd0);
    check("R8 tx clear valid", {31'b0, tx_valid}, 32'h0);

    // R4 / R5 receive fill, overrun, pops
    for (int i = 1; i <= 17; i++) begin
      rx_byte(8'h50 + 8'(i - 1));
      rd(5'd16, s);
      check("R4 rx count", rxc(s), (i > 16) ? 32'd16 : i);
      if (i == 16) check("R5 no overrun at 16", (s >> 2) & 32'h1, 32'd0);
    end
    rd(5'd16, s); check("R5 overrun set", (s >> 2) & 32'h1, 32'd1);
    for (int k = 0; k < 16; k++) begin
      action(32'h1 << 10);
      rd(5'd0, v); check("R4 pop data", v, 32'h50 + k);
      rd(5'd16, s); check("R4 count after pop", rxc(s), 15 - k);
    end
    action(32'h1 << 10);
    rd(5'd0, v); check("R4 pop empty keeps data", v, 32'h5F);
    rd(5'd16, s); check("R4 pop empty count", rxc(s), 32'd0);
    action(32'h2);
    rd(5'd16, s); check("R7 clear overrun", (s >> 2) & 32'h1, 32'd0);

    // R8 receive clear
    rx_byte(8'h11); rx_byte(8'h22);
    action(32'h1 << 11);
    rd(5'd16, s); check("R8 rx clear", rxc(s), 32'd0);

    // R10 receive-ready delay steps
    foreach (s[i]) begin end
    for (int di = 0; di < 4; di++) begin
      int d;
      d = (di == 3) ? 5 : di;
      wr(5'd4, d << 14);
      action(32'h1 | (32'h1 << 11));
      rx_byte(8'h77);
      for (int t = 0; t <= d; t++) begin
        idle(2);
        rd(5'd16, s);
        check("R10 rrdy after ticks", s & 32'h1, (t >= d) ? 32'd1 : 32'd0);
        if (t < d) tick_once();
      end
    end
    wr(5'd4, 32'h0);
    action(32'h1 << 11);
    action(32'h1F);

    // R6 error strobes
    @(negedge clk); rx_brk = 1; @(negedge clk); rx_brk = 0;
    rd(5'd16, s); check("R6 break", (s >> 3) & 32'h7, 32'h1);
    @(negedge clk); rx_fe = 1; @(negedge clk); rx_fe = 0;
    rd(5'd16, s); check("R6 framing", (s >> 3) & 32'h7, 32'h3);
    @(negedge clk); rx_pe = 1; @(negedge clk); rx_pe = 0;
    idle(2);
    rd(5'd16, s); check("R6 parity sticky", (s >> 3) & 32'h7, 32'h7);
    action(32'h1C);
    rd(5'd16, s); check("R7 clear errors", (s >> 3) & 32'h7, 32'h0);

    // R7 set actions and set-wins
    action(32'h3E0);
    rd(5'd16, s); check("R7 set all flags", s & 32'h3D, 32'h3D);
    action(32'h1F);
    rd(5'd16, s); check("R7 clear all flags", s & 32'h3D, 32'h0);
    action(32'h2 | 32'h40);
    rd(5'd16, s); check("R7 set wins over clear", (s >> 2) & 32'h1, 32'h1);
    action(32'h1F);

    // R11 interrupt enable mapping
    for (int i = 0; i < 5; i++) begin
      wr(5'd4, 32'h1 << i);
      idle(1);
      check("R11 irq off", {31'b0, irq}, 32'h0);
      action(32'h1 << (5 + i));
      idle(1);
      check("R11 irq on", {31'b0, irq}, 32'h1);
      action(32'h1 << i);
      idle(1);
      check("R11 irq cleared", {31'b0, irq}, 32'h0);
    end
    wr(5'd4, 32'h1F);
    idle(1);
    check("R11 irq trdy disabled", {31'b0, irq}, 32'h0);
    wr(5'd4, 32'h20);
    idle(1);
    check("R11 irq trdy enabled", {31'b0, irq}, 32'h1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule